// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the device side of a 64K x16 NOR flash model. It watches the write cycles that arrive on the bus, each marked by a one-cycle write strobe together with a 16-bit address and a 16-bit data word. It changes the array only after a guarded unlock handshake, and it picks one of three operations: word program, sector erase or chip erase. The operation depends on which command byte arrives in which cycle of the handshake.

When a full sequence has been accepted, the decoder latches the operands and starts an internal busy timer. For as long as that timer runs, it reports the operation kind to the array-update logic. The program address and data, and the erase sector number, stay on the outputs for that logic to use. Every write that arrives while the timer runs is dropped. Any write that does not match the current step of the handshake sends the decoder back to its starting step.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy is 0, op_kind is 0 (none), and prog_addr, prog_data and erase_sector are 0.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h, followed by one more write, start a word program. After the clock edge that samples the fourth write, op_kind is 1, and prog_addr and prog_data equal that write's address and data.
- R3: A program keeps busy high for exactly PROG_CYCLES clock cycles. Busy rises on the edge that samples the final write of the sequence.
- R4: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by 30h at any address, start a sector erase. op_kind is 2, erase_sector equals address bits 15..11 of the sixth write (2K-word sectors), and busy stays high for exactly ERASE_CYCLES cycles.
- R5: The same five-write prefix followed by 10h@5555h starts a chip erase. op_kind is 3, and busy stays high for ERASE_CYCLES cycles.
- R6: A write strobe while busy is 1 is ignored. It does not restart the timer, it does not change the latched operands, and it does not advance the handshake.
- R7: A write that does not match the expected address/byte pair for the current step returns the decoder to the first step without starting an operation.
- R8: In the handshake and command cycles, only data bits 7..0 and address bits 14..0 are compared. Upper bits are don't-care.
- R9: In the sixth cycle, 10h written to any address other than 5555h is rejected. 30h written to 5555h selects a sector erase of sector 10.
- R10: The fourth write of a program is taken as its operand whatever its value, and the decoder is back at the first step afterwards.
- R11: op_kind reads 0 whenever busy is 0. The latched operands hold their values after the operation ends, until the next operation of the same kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | One-cycle marker of a bus write cycle |
| wr_addr | input | 16 | Word address of the write cycle |
| wr_data | input | 16 | Data word of the write cycle |
| busy | output | 1 | Internal program or erase in progress |
| op_kind | output | 2 | 0 none, 1 program, 2 sector erase, 3 chip erase (non-zero only while busy) |
| prog_addr | output | 16 | Latched program address |
| prog_data | output | 16 | Latched program data |
| erase_sector | output | 5 | Latched sector number of the last sector erase |

## Verification
The decoder is driven with complete program, sector-erase and chip-erase handshakes over several addresses and data words. These runs tell apart the kind that was selected, the operands that were latched and the busy length of each kind. Broken handshakes, with a wrong byte at the third, fifth or sixth step, and the wrong-address chip opcode separate a proper return to idle from a partial acceptance. Handshakes with upper bits set show that only the low bits are compared. Unlock writes issued during busy, followed by a lone data word after busy ends, show that writes during busy leave no decoder state behind. A program whose operand is itself AAh@5555h shows that the operand cycle never restarts the unlock.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PROG = 2'd1,
      OP_SECT = 2'd2,
      OP_CHIP = 2'd3
   } fcs_op_e;

   typedef enum logic [2:0] {
      S_IDLE, S_U2, S_CMD, S_PROG, S_EU1, S_EU2, S_ESEL
   } fcs_step_e;

   // index 0: first unlock address, index 1: second unlock address
   localparam logic [1:0][15:0] UNLOCK_ADDR = {16'h2AAA, 16'h5555};

   localparam logic [7:0] KEY_A     = 8'hAA;
   localparam logic [7:0] KEY_B     = 8'h55;
   localparam logic [7:0] CMD_PROG  = 8'hA0;
   localparam logic [7:0] CMD_ERASE = 8'h80;
   localparam logic [7:0] SEL_CHIP  = 8'h10;
   localparam logic [7:0] SEL_SECT  = 8'h30;

endpackage

// File: rtl/fcs_match.sv
module fcs_match #(
   parameter int unsigned W = 15,
   parameter logic [W-1:0] REF = '0
) (
   input  logic [W-1:0] addr,
   output logic         hit
);
   assign hit = (addr == REF);
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
   import fcs_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       accept,
   input  logic [7:0] cmd_byte,
   input  logic       hit_a,
   input  logic       hit_b,
   output logic       start,
   output fcs_op_e    start_op
);
   fcs_step_e step_q, step_d;

   always_comb begin
      step_d   = step_q;
      start    = 1'b0;
      start_op = OP_NONE;
      if (accept) begin
         step_d = S_IDLE;
         unique case (step_q)
            S_IDLE: if (hit_a && cmd_byte == KEY_A) step_d = S_U2;
            S_U2:   if (hit_b && cmd_byte == KEY_B) step_d = S_CMD;
            S_CMD: begin
               if (hit_a && cmd_byte == CMD_PROG)       step_d = S_PROG;
               else if (hit_a && cmd_byte == CMD_ERASE) step_d = S_EU1;
            end
            S_PROG: begin
               start    = 1'b1;
               start_op = OP_PROG;
            end
            S_EU1:  if (hit_a && cmd_byte == KEY_A) step_d = S_EU2;
            S_EU2:  if (hit_b && cmd_byte == KEY_B) step_d = S_ESEL;
            S_ESEL: begin
               if (hit_a && cmd_byte == SEL_CHIP) begin
                  start    = 1'b1;
                  start_op = OP_CHIP;
               end else if (cmd_byte == SEL_SECT) begin
                  start    = 1'b1;
                  start_op = OP_SECT;
               end
            end
            default: step_d = S_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) step_q <= S_IDLE;
      else        step_q <= step_d;
   end
endmodule

// File: rtl/fcs_timer.sv
module fcs_timer
   import fcs_pkg::*;
#(
   parameter int unsigned PROG_CYCLES  = 40,
   parameter int unsigned ERASE_CYCLES = 200
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start,
   input  fcs_op_e start_op,
   output logic    busy
);
   localparam int unsigned MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
   localparam int unsigned CNTW = $clog2(MAXC + 1);

   logic [CNTW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         cnt_q <= '0;
      end else if (start) begin
         busy  <= 1'b1;
         cnt_q <= (start_op == OP_PROG) ? CNTW'(PROG_CYCLES - 1) : CNTW'(ERASE_CYCLES - 1);
      end else if (busy) begin
         if (cnt_q == '0) busy  <= 1'b0;
         else             cnt_q <= cnt_q - 1'b1;
      end
   end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
   import fcs_pkg::*;
#(
   parameter int unsigned AW           = 16,
   parameter int unsigned DW           = 16,
   parameter int unsigned CMP_ABITS    = 15,
   parameter int unsigned SECTOR_WORDS = 2048,
   parameter int unsigned PROG_CYCLES  = 40,
   parameter int unsigned ERASE_CYCLES = 200
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_stb,
   input  logic [AW-1:0]                     wr_addr,
   input  logic [DW-1:0]                     wr_data,
   output logic                              busy,
   output logic [1:0]                        op_kind,
   output logic [AW-1:0]                     prog_addr,
   output logic [DW-1:0]                     prog_data,
   output logic [AW-$clog2(SECTOR_WORDS)-1:0] erase_sector
);
   localparam int unsigned SEC_LSB = $clog2(SECTOR_WORDS);
   localparam int unsigned SW      = AW - SEC_LSB;

   generate
      if (AW < 16 || DW < 8)
         $error("flash_cmd_seq: AW must be at least 16 and DW at least 8");
      if (CMP_ABITS < 14 || CMP_ABITS > 16 || CMP_ABITS > AW)
         $error("flash_cmd_seq: CMP_ABITS must lie in 14..16 and not exceed AW");
      if ((1 << SEC_LSB) != SECTOR_WORDS || SEC_LSB >= AW)
         $error("flash_cmd_seq: SECTOR_WORDS must be a power of two below 2**AW");
      if (PROG_CYCLES < 1 || ERASE_CYCLES < 1)
         $error("flash_cmd_seq: busy lengths must be at least one cycle");
   endgenerate

   logic [1:0] hit;
   logic       accept, start;
   fcs_op_e    start_op, kind_q;

   for (genvar i = 0; i < 2; i++) begin : g_unlock
      fcs_match #(
         .W  (CMP_ABITS),
         .REF(UNLOCK_ADDR[i][CMP_ABITS-1:0])
      ) u_match (
         .addr(wr_addr[CMP_ABITS-1:0]),
         .hit (hit[i])
      );
   end

   assign accept = wr_stb & ~busy;

   fcs_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .cmd_byte(wr_data[7:0]),
      .hit_a   (hit[0]),
      .hit_b   (hit[1]),
      .start   (start),
      .start_op(start_op)
   );

   fcs_timer #(
      .PROG_CYCLES (PROG_CYCLES),
      .ERASE_CYCLES(ERASE_CYCLES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .start_op(start_op),
      .busy    (busy)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q       <= OP_NONE;
         prog_addr    <= '0;
         prog_data    <= '0;
         erase_sector <= '0;
      end else if (start) begin
         kind_q <= start_op;
         if (start_op == OP_PROG) begin
            prog_addr <= wr_addr;
            prog_data <= wr_data;
         end
         if (start_op == OP_SECT) erase_sector <= wr_addr[AW-1:SEC_LSB];
      end
   end

   assign op_kind = busy ? kind_q : OP_NONE;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
   import fcs_pkg::*;
#(
   parameter int unsigned AW           = 16,
   parameter int unsigned DW           = 16,
   parameter int unsigned SW           = 5,
   parameter int unsigned ERASE_CYCLES = 200
) (
   input logic          clk,
   input logic          rst_n,
   input logic          wr_stb,
   input logic [AW-1:0] wr_addr,
   input logic [DW-1:0] wr_data,
   input logic          busy,
   input logic [1:0]    op_kind,
   input logic [AW-1:0] prog_addr,
   input logic [DW-1:0] prog_data,
   input logic [SW-1:0] erase_sector
);
   int unsigned run_q;

   always_ff @(posedge clk) begin
      if (!rst_n)    run_q <= 0;
      else if (busy) run_q <= run_q + 1;
      else           run_q <= 0;
   end

   p_busy_shows_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> op_kind != OP_NONE);

   p_idle_no_op_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> op_kind == OP_NONE);

   p_start_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(wr_stb));

   p_prog_operands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && op_kind == OP_PROG) |->
         (prog_addr == $past(wr_addr) && prog_data == $past(wr_data)));

   p_sector_number_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && op_kind == OP_SECT) |->
         (erase_sector == $past(wr_addr[AW-1:AW-SW]) && $past(wr_data[7:0]) == SEL_SECT));

   p_chip_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(busy) && op_kind == OP_CHIP) |-> $past(wr_data[7:0]) == SEL_CHIP);

   p_ignore_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_stb) |=>
         ($stable(prog_addr) && $stable(prog_data) && $stable(erase_sector)));

   p_busy_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> run_q < ERASE_CYCLES);
endmodule

bind flash_cmd_seq fcs_checker #(
   .AW          (AW),
   .DW          (DW),
   .SW          (SW),
   .ERASE_CYCLES((ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_stb      (wr_stb),
   .wr_addr     (wr_addr),
   .wr_data     (wr_data),
   .busy        (busy),
   .op_kind     (op_kind),
   .prog_addr   (prog_addr),
   .prog_data   (prog_data),
   .erase_sector(erase_sector)
);

// File: tb/sim_flash_cmd_seq.sv
module sim_flash_cmd_seq;
   localparam int PROG_N  = 40;
   localparam int ERASE_N = 200;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        busy;
   logic [1:0]  op_kind;
   logic [15:0] prog_addr, prog_data;
   logic [4:0]  erase_sector;

   int n_cmp = 0;
   int n_bad = 0;

   typedef struct {
      logic [1:0]  op;
      logic [15:0] a;
      logic [15:0] d;
      logic [4:0]  s;
      int          len;
      string       req;
   } item_t;

   item_t exp_q[$];
   item_t cur;
   logic  prev_busy = 1'b0;
   int    run = 0;

   always #10 clk = ~clk;

   flash_cmd_seq #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy), .op_kind(op_kind), .prog_addr(prog_addr), .prog_data(prog_data),
      .erase_sector(erase_sector)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: pops an expected item when an operation starts, times its busy window
   always @(negedge clk) begin
      if (!rst_n) begin
         prev_busy = 1'b0;
         run = 0;
      end else begin
         if (busy && !prev_busy) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R6/R7 unexpected start", {30'd0, op_kind}, 32'd0);
               cur = '{op: op_kind, a: '0, d: '0, s: '0, len: 0, req: "R6/R7 unexpected start"};
            end else begin
               cur = exp_q.pop_front();
               chk(op_kind == cur.op, cur.req, {30'd0, op_kind}, {30'd0, cur.op});
               if (cur.op == 2'd1) begin
                  chk(prog_addr == cur.a, cur.req, {16'd0, prog_addr}, {16'd0, cur.a});
                  chk(prog_data == cur.d, cur.req, {16'd0, prog_data}, {16'd0, cur.d});
               end
               if (cur.op == 2'd2)
                  chk(erase_sector == cur.s, cur.req, {27'd0, erase_sector}, {27'd0, cur.s});
            end
            run = 1;
         end else if (busy) begin
            run++;
         end else if (prev_busy && cur.len != 0) begin
            chk(run == cur.len, {cur.req, " busy length"}, run, cur.len);
         end
         prev_busy = busy;
      end
   end

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      wr_stb  = 1'b1;
      wr_addr = a;
      wr_data = d;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic unlock();
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAA, 16'h0055);
   endtask

   task automatic do_prog(input logic [15:0] a, input logic [15:0] d, input string req);
      unlock();
      wr(16'h5555, 16'h00A0);
      exp_q.push_back('{op: 2'd1, a: a, d: d, s: '0, len: PROG_N, req: req});
      wr(a, d);
   endtask

   task automatic erase_prefix();
      unlock();
      wr(16'h5555, 16'h0080);
      unlock();
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(20 * 100000);
      chk(1'b0, "R1 watchdog expired", 32'd0, 32'd1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(busy == 1'b0, "R1 busy", {31'd0, busy}, 32'd0);
      chk(op_kind == 2'd0, "R1 op_kind", {30'd0, op_kind}, 32'd0);
      chk(prog_addr == 16'd0 && prog_data == 16'd0 && erase_sector == 5'd0,
          "R1 operands", {prog_addr, prog_data}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 R3: program patterns
      do_prog(16'h1234, 16'hBEEF, "R2/R3 program 1234");
      wait_idle();
      do_prog(16'hFFFF, 16'h0000, "R2/R3 program FFFF");
      wait_idle();
      // R10: operand equal to the first unlock pair
      do_prog(16'h5555, 16'h00AA, "R10 program operand AA@5555");
      wait_idle();
      wr(16'h2AAA, 16'h0055);
      wr(16'h5555, 16'h00A0);
      wr(16'h0100, 16'h0001);
      @(negedge clk);
      chk(busy == 1'b0, "R10 decoder back at first step", {31'd0, busy}, 32'd0);
      // R11: idle reads none, operands held
      chk(op_kind == 2'd0, "R11 idle op_kind", {30'd0, op_kind}, 32'd0);
      chk(prog_addr == 16'h5555, "R11 prog_addr held", {16'd0, prog_addr}, 32'h5555);

      // R4: sector erase
      erase_prefix();
      exp_q.push_back('{op: 2'd2, a: '0, d: '0, s: 5'd31, len: ERASE_N, req: "R4 sector F800"});
      wr(16'hF800, 16'h0030);
      wait_idle();
      erase_prefix();
      exp_q.push_back('{op: 2'd2, a: '0, d: '0, s: 5'd1, len: ERASE_N, req: "R4 sector 0FFF"});
      wr(16'h0FFF, 16'h0030);
      wait_idle();
      chk(prog_addr == 16'h5555, "R11 prog_addr kept across erase", {16'd0, prog_addr}, 32'h5555);

      // R5: chip erase
      erase_prefix();
      exp_q.push_back('{op: 2'd3, a: '0, d: '0, s: '0, len: ERASE_N, req: "R5 chip erase"});
      wr(16'h5555, 16'h0010);
      wait_idle();

      // R9: last-cycle corner cases
      erase_prefix();
      wr(16'h1234, 16'h0010);
      @(negedge clk);
      chk(busy == 1'b0, "R9 10h at wrong address rejected", {31'd0, busy}, 32'd0);
      erase_prefix();
      exp_q.push_back('{op: 2'd2, a: '0, d: '0, s: 5'd10, len: ERASE_N, req: "R9 30h@5555 sector"});
      wr(16'h5555, 16'h0030);
      wait_idle();

      // R6: writes during busy are ignored
      do_prog(16'h0A0A, 16'h1111, "R6 program under attack");
      do_prog(16'h0B0B, 16'h2222, "R6 ignored");
      void'(exp_q.pop_back());
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAA, 16'h0055);
      wr(16'h5555, 16'h00A0);
      wait_idle();
      chk(prog_addr == 16'h0A0A, "R6 prog_addr unchanged", {16'd0, prog_addr}, 32'h0A0A);
      chk(prog_data == 16'h1111, "R6 prog_data unchanged", {16'd0, prog_data}, 32'h1111);
      wr(16'h0C0C, 16'h3333);
      @(negedge clk);
      chk(busy == 1'b0, "R6 no handshake carried over", {31'd0, busy}, 32'd0);
      erase_prefix();
      exp_q.push_back('{op: 2'd2, a: '0, d: '0, s: 5'd3, len: ERASE_N, req: "R6 erase under attack"});
      wr(16'h1800, 16'h0030);
      erase_prefix();
      wr(16'h5555, 16'h0010);
      wait_idle();
      chk(erase_sector == 5'd3, "R6 erase_sector unchanged", {27'd0, erase_sector}, 32'd3);

      // R7: mismatches return to the first step
      unlock();
      wr(16'h5555, 16'h0077);
      wr(16'h1111, 16'h2222);
      @(negedge clk);
      chk(busy == 1'b0, "R7 wrong command byte", {31'd0, busy}, 32'd0);
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAA, 16'h0056);
      wr(16'h5555, 16'h00A0);
      wr(16'h2222, 16'h3333);
      @(negedge clk);
      chk(busy == 1'b0, "R7 wrong second key", {31'd0, busy}, 32'd0);
      unlock();
      wr(16'h5555, 16'h0080);
      wr(16'h5555, 16'h00AA);
      wr(16'h2AAB, 16'h0055);
      wr(16'h5555, 16'h0010);
      @(negedge clk);
      chk(busy == 1'b0, "R7 erase broken at fifth cycle", {31'd0, busy}, 32'd0);
      do_prog(16'h4242, 16'h7E7E, "R7 valid after mismatch");
      wait_idle();

      // R8: upper address and data bits are don't-care
      wr(16'hD555, 16'h12AA);
      wr(16'hAAAA, 16'h3455);
      wr(16'hD555, 16'hFFA0);
      exp_q.push_back('{op: 2'd1, a: 16'h9999, d: 16'hCAFE, s: '0, len: PROG_N, req: "R8 program upper bits"});
      wr(16'h9999, 16'hCAFE);
      wait_idle();
      wr(16'hD555, 16'h01AA);
      wr(16'hAAAA, 16'h0255);
      wr(16'hD555, 16'h0380);
      wr(16'hD555, 16'h04AA);
      wr(16'hAAAA, 16'h0555);
      exp_q.push_back('{op: 2'd2, a: '0, d: '0, s: 5'd20, len: ERASE_N, req: "R8 sector upper bits"});
      wr(16'hA000, 16'hFF30);
      wait_idle();

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R2 all expected operations seen", exp_q.size(), 32'd0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule